// File: doc/BRIEF.md
# Dual-Clock Line Buffer with Transfer Requests

This block is a first-in first-out buffer that joins two unrelated clock domains. A bus master writes whole words on one clock. A pixel consumer drains narrower pixels from those words on a second clock. The buffer keeps its own write and read positions, so neither side supplies an address, and the two sides can work at the same time without any handshake between them.

Each stored word is split into pixels, lowest byte lane first. The read side moves forward only on cycles where the display timing marks an active pixel. Two request outputs pace the transfers. A read-domain half-level flag serves an acquisition configuration: a drain engine watches it and empties the buffer. A write-domain line request serves a display configuration: it tells the processor to send the next line once fewer than one line of words remains. With `PIX_W` equal to `WORD_W`, the same block acts as a plain same-width buffer for sample streams.

Top module: `line_cdc_fifo`

## Requirements
- R1: While either reset is held and on the cycle after it is released, the outputs are: `rd_empty`=1, `wr_full`=0, `pix_valid`=0, `wr_err`=0, `rd_err`=0, `half_req`=0 and `line_req`=1.
- R2: Words leave in the order they were written. The block has no address input.
- R3: Each word yields `WORD_W/PIX_W` pixels. Pixel k is bits [k*PIX_W+PIX_W-1 : k*PIX_W], starting with k=0 (least-significant byte first).
- R4: A pixel is consumed only on a `rd_clk` cycle with `pix_active`=1 while the buffer is not empty. `pix_valid` rises on the next cycle with that pixel on `pix_data`. Inactive cycles give `pix_valid`=0 and consume nothing.
- R5: `wr_full` is 1 once `2**DEPTH_LOG2` words are stored. A write while full stores nothing and sets `wr_err`, which stays at 1 until `wr_rst`.
- R6: `pix_active` while empty yields no pixel and leaves the read position unchanged. It sets `rd_err`, which stays at 1 until `rd_rst`.
- R7: `half_req` (read domain) is 1 when the stored word count is at least half the depth, and 0 otherwise.
- R8: `line_req` (write domain) goes to 1 when the stored word count falls from at least `LINE_WORDS` to below it. It clears on the next accepted write.
- R9: The two clocks are unrelated. Positions cross between domains in Gray code, changing one bit per step, and concurrent writing and reading loses or duplicates no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Bus-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WORD_W | Word to store |
| wr_full | output | 1 | Buffer holds its full depth |
| wr_err | output | 1 | Sticky: a write was refused |
| line_req | output | 1 | Request for the next line of words |
| rd_clk | input | 1 | Pixel clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| pix_active | input | 1 | Display timing marks an active pixel |
| pix_data | output | PIX_W | Current pixel |
| pix_valid | output | 1 | `pix_data` holds a freshly consumed pixel |
| rd_empty | output | 1 | No word is available to the read side |
| rd_err | output | 1 | Sticky: an active cycle found the buffer empty |
| half_req | output | 1 | At least half the depth is occupied |

## Verification
A wrong read position shows up as a wrong pixel within one pixel-clock cycle of the consuming active cycle. A broken byte-lane counter shows up at the latest on the fourth pixel of a word. A fault in a Gray position or its synchronizer appears as a lost, repeated or stale word during concurrent streaming, or as a full or empty flag that never clears. A fault in the level logic is visible on `half_req` or `line_req` within a few cycles of the count crossing its threshold.

// File: rtl/lcf_pkg.sv
package lcf_pkg;
  localparam int PTR_MAX_W = 16;
  typedef logic [PTR_MAX_W-1:0] ptr_t;

  function automatic ptr_t to_gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t from_gray(input ptr_t g);
    ptr_t b;
    b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
    for (int i = PTR_MAX_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/lcf_sync.sv
module lcf_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/lcf_mem.sv
module lcf_mem #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/lcf_wr_ctrl.sv
module lcf_wr_ctrl
  import lcf_pkg::*;
#(
  parameter int AW         = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_en,
  input  logic [AW:0]   rd_gray_s,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wr_gray,
  output logic          full,
  output logic          wr_err,
  output logic          line_req
);
  localparam int PW = AW + 1;

  logic [AW:0] wr_bin, wr_bin_n, rd_bin_s, occ;
  logic        below, below_q;

  assign rd_bin_s = PW'(from_gray(PTR_MAX_W'(rd_gray_s)));
  assign occ      = wr_bin - rd_bin_s;
  assign below    = occ < PW'(LINE_WORDS);
  assign full     = wr_gray == {~rd_gray_s[AW:AW-1], rd_gray_s[AW-2:0]};
  assign push     = wr_en && !full;
  assign wr_bin_n = wr_bin + 1'b1;
  assign waddr    = wr_bin[AW-1:0];

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wr_bin   <= '0;
      wr_gray  <= '0;
      wr_err   <= 1'b0;
      below_q  <= 1'b1;
      line_req <= 1'b1;
    end else begin
      if (push) begin
        wr_bin  <= wr_bin_n;
        wr_gray <= PW'(to_gray(PTR_MAX_W'(wr_bin_n)));
      end
      if (wr_en && full) wr_err <= 1'b1;
      below_q <= below;
      if (below && !below_q) line_req <= 1'b1;
      else if (push)         line_req <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (wr_rst)
    full |=> $stable(wr_bin)); // R5
  AST_WR_ERR_STICKY: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_err |=> wr_err); // R5
  AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(wr_gray ^ $past(wr_gray)) <= 1); // R9
  AST_LINE_REQ_ON_DROP: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $rose(line_req) |-> $past(below)); // R8
endmodule

// File: rtl/lcf_rd_ctrl.sv
module lcf_rd_ctrl
  import lcf_pkg::*;
#(
  parameter int AW     = 4,
  parameter int RATIO  = 4,
  parameter int LANE_W = 2
) (
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              pix_active,
  input  logic [AW:0]       wr_gray_s,
  output logic              take,
  output logic [AW-1:0]     raddr,
  output logic [AW:0]       rd_gray,
  output logic [LANE_W-1:0] lane_sel,
  output logic              pix_valid,
  output logic              empty,
  output logic              rd_err,
  output logic              half_req
);
  localparam int PW   = AW + 1;
  localparam int HALF = 2 ** (AW - 1);

  logic [AW:0]       rd_bin, rd_bin_n, wr_bin_s, occ;
  logic [LANE_W-1:0] lane;
  logic              last_lane, pop;

  assign wr_bin_s = PW'(from_gray(PTR_MAX_W'(wr_gray_s)));
  assign occ      = wr_bin_s - rd_bin;
  assign empty    = rd_gray == wr_gray_s;
  assign take     = pix_active && !empty;
  assign pop      = take && last_lane;
  assign rd_bin_n = rd_bin + 1'b1;
  assign raddr    = rd_bin[AW-1:0];

  generate
    if (RATIO > 1) begin : g_lanes
      always_ff @(posedge rd_clk) begin
        if (rd_rst)    lane <= '0;
        else if (take) lane <= last_lane ? '0 : lane + 1'b1;
      end
      assign last_lane = lane == LANE_W'(RATIO - 1);
    end else begin : g_single
      assign lane      = '0;
      assign last_lane = 1'b1;
    end
  endgenerate

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rd_bin    <= '0;
      rd_gray   <= '0;
      lane_sel  <= '0;
      pix_valid <= 1'b0;
      rd_err    <= 1'b0;
      half_req  <= 1'b0;
    end else begin
      if (pop) begin
        rd_bin  <= rd_bin_n;
        rd_gray <= PW'(to_gray(PTR_MAX_W'(rd_bin_n)));
      end
      if (take) lane_sel <= lane;
      pix_valid <= take;
      if (pix_active && empty) rd_err <= 1'b1;
      half_req <= occ >= PW'(HALF);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rd_rst)
    empty |=> $stable(rd_bin)); // R6
  AST_RD_ERR_STICKY: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_err |=> rd_err); // R6
  AST_VALID_NEEDS_ACTIVE: assert property (@(posedge rd_clk) disable iff (rd_rst)
    pix_valid |-> $past(pix_active)); // R4
  AST_HALF_NOT_EMPTY: assert property (@(posedge rd_clk) disable iff (rd_rst)
    half_req |-> !empty); // R7
  AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $countones(rd_gray ^ $past(rd_gray)) <= 1); // R9
endmodule

// File: rtl/line_cdc_fifo.sv
module line_cdc_fifo #(
  parameter int WORD_W     = 32,
  parameter int PIX_W      = 8,
  parameter int DEPTH_LOG2 = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_err,
  output logic              line_req,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              pix_active,
  output logic [PIX_W-1:0]  pix_data,
  output logic              pix_valid,
  output logic              rd_empty,
  output logic              rd_err,
  output logic              half_req
);
  localparam int AW     = DEPTH_LOG2;
  localparam int RATIO  = WORD_W / PIX_W;
  localparam int LANE_W = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [AW:0]       wr_gray, wr_gray_s, rd_gray, rd_gray_s;
  logic [AW-1:0]     waddr, raddr;
  logic              push, take;
  logic [LANE_W-1:0] lane_sel;
  logic [WORD_W-1:0] rd_word;

  lcf_wr_ctrl #(.AW(AW), .LINE_WORDS(LINE_WORDS)) u_wr (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .rd_gray_s(rd_gray_s),
    .push(push), .waddr(waddr), .wr_gray(wr_gray), .full(wr_full),
    .wr_err(wr_err), .line_req(line_req)
  );

  lcf_sync #(.W(AW + 1)) u_sync_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_s)
  );

  lcf_sync #(.W(AW + 1)) u_sync_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_s)
  );

  lcf_rd_ctrl #(.AW(AW), .RATIO(RATIO), .LANE_W(LANE_W)) u_rd (
    .rd_clk(rd_clk), .rd_rst(rd_rst), .pix_active(pix_active),
    .wr_gray_s(wr_gray_s), .take(take), .raddr(raddr), .rd_gray(rd_gray),
    .lane_sel(lane_sel), .pix_valid(pix_valid), .empty(rd_empty),
    .rd_err(rd_err), .half_req(half_req)
  );

  lcf_mem #(.DW(WORD_W), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .re(take), .raddr(raddr), .rdata(rd_word)
  );

  assign pix_data = rd_word[int'(lane_sel)*PIX_W +: PIX_W];

  initial begin
    AST_PARAM_SHAPE: assert (DEPTH_LOG2 >= 2 && DEPTH_LOG2 < 16 && RATIO * PIX_W == WORD_W); // R3
  end
endmodule

// File: tb/tb_line_cdc_fifo.sv
module tb_line_cdc_fifo;
  localparam int DEPTH = 16;

  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        wr_rst = 1'b1, rd_rst = 1'b1;
  logic        wr_en = 1'b0, pix_active = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  pix_data;
  logic        wr_full, wr_err, line_req, pix_valid, rd_empty, rd_err, half_req;

  int n_checks = 0, n_fail = 0;

  always #4   wr_clk = ~wr_clk;   // 125 MHz
  always #5.5 rd_clk = ~rd_clk;   // unrelated pixel clock

  line_cdc_fifo dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_err(wr_err), .line_req(line_req),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .pix_active(pix_active),
    .pix_data(pix_data), .pix_valid(pix_valid), .rd_empty(rd_empty),
    .rd_err(rd_err), .half_req(half_req)
  );

  localparam logic [31:0] VEC [8] = '{
    32'h04030201, 32'h8899AABB, 32'hFF00FF00, 32'h12345678,
    32'hDEADBEEF, 32'h0F1E2D3C, 32'hA5A55A5A, 32'h00000080
  };

  function automatic logic [31:0] stream_word(input int i);
    return 32'hC0000000 ^ (i * 32'h01030507);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_word(input logic [31:0] w);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic get_pixel(input logic [7:0] exp, input string tag);
    @(negedge rd_clk);
    pix_active = 1'b1;
    @(negedge rd_clk);
    pix_active = 1'b0;
    check(pix_valid == 1'b1 && pix_data == exp, tag, {23'd0, pix_valid, pix_data}, {24'd1, exp});
  endtask

  task automatic get_word(input logic [31:0] w, input string tag);
    for (int k = 0; k < 4; k++) get_pixel(w[k*8 +: 8], tag);
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1_600_000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge wr_clk);
    // R1: reset state while both resets held
    check(rd_empty && !wr_full && !pix_valid && !wr_err && !rd_err && !half_req && line_req,
          "R1 reset outputs", {25'd0, rd_empty, wr_full, pix_valid, wr_err, rd_err, half_req, line_req},
          32'b1000001);
    wr_rst = 1'b0;
    @(negedge rd_clk);
    rd_rst = 1'b0;
    @(negedge rd_clk);
    check(rd_empty && !pix_valid && !rd_err && !half_req, "R1 read side after release",
          {28'd0, rd_empty, pix_valid, rd_err, half_req}, 32'b1000);

    // Vector table: store then drain, least-significant byte first
    put_word(VEC[0]);
    check(!line_req, "R8 first write clears line_req", {31'd0, line_req}, 32'd0);
    for (int i = 1; i < 8; i++) put_word(VEC[i]);
    settle();
    check(half_req && !rd_empty, "R7 half level at 8 of 16", {30'd0, half_req, rd_empty}, 32'b10);
    check(!line_req, "R8 no request while filling", {31'd0, line_req}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      get_word(VEC[i], "R2 R3 table order and byte lanes");
      if (i == 2) begin
        repeat (3) @(negedge rd_clk);
        check(!pix_valid, "R4 idle cycles yield no pixel", {31'd0, pix_valid}, 32'd0);
      end
    end
    settle();
    check(rd_empty && !half_req, "R7 drained, half_req low", {30'd0, rd_empty, half_req}, 32'b10);
    check(line_req, "R8 drop below one line raises line_req", {31'd0, line_req}, 32'd1);
    check(!rd_err, "R6 no underflow yet", {31'd0, rd_err}, 32'd0);

    // Concurrent streaming across both clocks
    fork
      begin
        for (int i = 0; i < 24; i++) begin
          @(negedge wr_clk);
          while (wr_full) @(negedge wr_clk);
          wr_en = 1'b1; wr_data = stream_word(i);
          @(negedge wr_clk);
          wr_en = 1'b0;
        end
      end
      begin
        for (int w = 0; w < 24; w++) begin
          for (int k = 0; k < 4; k++) begin
            @(negedge rd_clk);
            while (rd_empty) @(negedge rd_clk);
            pix_active = 1'b1;
            @(negedge rd_clk);
            pix_active = 1'b0;
            check(pix_valid && pix_data == stream_word(w)[k*8 +: 8], "R9 concurrent stream",
                  {23'd0, pix_valid, pix_data}, {24'd1, stream_word(w)[k*8 +: 8]});
          end
        end
      end
    join
    settle();
    check(!wr_err && !rd_err, "R9 no refusals while streaming", {30'd0, wr_err, rd_err}, 32'd0);

    // Fill to depth, then overflow
    for (int i = 0; i < DEPTH; i++) put_word(32'h10000000 + i * 32'h00010101);
    check(wr_full, "R5 full at depth", {31'd0, wr_full}, 32'd1);
    put_word(32'hBADC0FFE);
    check(wr_err && wr_full, "R5 refused write sets wr_err", {30'd0, wr_err, wr_full}, 32'b11);
    settle();
    check(half_req, "R7 half level when full", {31'd0, half_req}, 32'd1);
    for (int i = 0; i < DEPTH; i++) get_word(32'h10000000 + i * 32'h00010101, "R5 stored words intact");
    settle();
    check(rd_empty, "R5 refused word never stored", {31'd0, rd_empty}, 32'd1);
    check(line_req && !half_req && !wr_full, "R8 R7 levels after drain",
          {29'd0, line_req, half_req, wr_full}, 32'b100);
    check(wr_err, "R5 wr_err sticky", {31'd0, wr_err}, 32'd1);

    // Underflow
    @(negedge rd_clk);
    pix_active = 1'b1;
    @(negedge rd_clk);
    pix_active = 1'b0;
    check(!pix_valid && rd_err, "R6 active while empty", {30'd0, pix_valid, rd_err}, 32'b01);
    put_word(32'h44332211);
    settle();
    get_word(32'h44332211, "R6 read position unmoved by underflow");
    repeat (4) @(negedge rd_clk);
    check(rd_err, "R6 rd_err sticky", {31'd0, rd_err}, 32'd1);

    // Reset clears sticky errors
    @(negedge wr_clk); wr_rst = 1'b1;
    @(negedge rd_clk); rd_rst = 1'b1;
    repeat (3) @(negedge wr_clk);
    check(!wr_err && !rd_err && line_req && rd_empty, "R1 reset clears state",
          {28'd0, wr_err, rd_err, line_req, rd_empty}, 32'b0011);
    finish_run();
  end
endmodule